// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block sits in the receive byte stream of an Ethernet MAC, after the frame has been assembled into bytes and before it is handed to host memory. When stripping is enabled and the frame's length field declares a payload shorter than the minimum of 46 bytes, the block forwards only the 14 header bytes and the declared payload. The pad bytes and the trailing 4-byte FCS are removed together, because the FCS no longer covers the shortened data. Frames with a larger length field, frames carrying an EtherType, and all frames while stripping is disabled pass through unmodified.

The output is the input delayed by one register. Each accepted input byte produces at most one output byte in the following cycle. Removed bytes leave a cycle with `out_valid` low, and no other gaps are added. A separate flag reports the illegal configuration in which pad stripping and receive checksum offload are enabled together.

The control is a five-state machine:
- IDLE: outside a frame; bytes are dropped.
- HDR: header bytes 0 to 13 are forwarded.
- PASS: the rest of an unstripped frame is forwarded.
- KEEP: declared payload bytes of a stripped frame are forwarded.
- DROP: pad and FCS of a stripped frame are discarded.

Its transitions are:
- Any state goes to HDR on a start-of-frame byte.
- HDR goes to PASS when the frame is not stripped.
- HDR goes to KEEP when the frame is stripped with a length of 1 to 45.
- HDR goes to DROP when the frame is stripped with a length of 0.
- KEEP goes to DROP after the last declared byte.
- Any state goes to IDLE on an end-of-frame byte.

Top module: `rxs_pad_strip`

## Requirements
- R1: With stripping disabled, the block forwards every in-frame byte with its data, start and end markers unchanged, one cycle later.
- R2: The length field is the byte at offset 12 (high half) and the byte at offset 13 (low half), counted from the start-of-frame byte at offset 0. The enable is sampled on the start-of-frame byte, so a change later in the frame has no effect on that frame.
- R3: With stripping enabled and a length value L below 46, only bytes 0 to 13+L are forwarded; every later byte, including the FCS, is suppressed.
- R4: In a stripped frame, `out_eof` is set on byte 13+L, which is byte 13 when L is 0, and on no other byte.
- R5: A frame whose length value is 46 or more passes unmodified with its FCS. This includes EtherType values above 1500.
- R6: A stripped frame that ends before byte 13+L is forwarded completely, with its own end marker.
- R7: The output carries data exactly one cycle after the accepted input byte, and `out_valid` is never high in a cycle after one without `in_valid`.
- R8: `cfg_err` is high in the cycle after both `strip_en` and `csum_en` are high, and low after any cycle in which they are not both high.
- R9: A start-of-frame byte always begins a new frame, even when the previous frame had no end marker.
- R10: Bytes that arrive with `in_valid` high between an end-of-frame byte and the next start-of-frame byte are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strip_en | input | 1 | Enables pad and FCS stripping |
| csum_en | input | 1 | Receive checksum offload enable, used only for the conflict check |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_eof | output | 1 | Output byte is the last byte of a frame |
| out_data | output | 8 | Output byte |
| cfg_err | output | 1 | Stripping and checksum offload are both enabled |

## Verification
The bench drives frames with lengths L = 0, 10, 45, 46 and an EtherType value, and checks where `out_eof` lands in each.
- A design off by one in the byte count would keep a pad byte or lose the last payload byte.
- A design mishandling L = 0 would fail to close the frame on header byte 13.

The bench also covers three cases where a design could go wrong in other ways:
- A runt frame that ends before its declared length; a wrong design would lose the real end marker.
- An enable that changes in mid-frame; a wrong design would switch between stripping and passing inside one frame.
- A stray byte between frames, and a frame restarted without an end marker; a wrong design would leak the stray byte or misplace the next frame's length field.

Idle cycles are inserted inside the frames to show that byte counting follows `in_valid` and not the clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_PASS,
        S_KEEP,
        S_DROP
    } rxs_state_e;
endpackage

// File: rtl/rxs_hdr_track.sv
// Counts byte position inside the frame and captures the length field.
module rxs_hdr_track #(
    parameter int DATA_W  = 8,
    parameter int LEN_POS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic [DATA_W-1:0]   in_data,
    output logic                at_len_lo,
    output logic [2*DATA_W-1:0] len_val
);
    localparam int CNT_W = $clog2(LEN_POS + 3);
    localparam logic [CNT_W-1:0] POS_HI = CNT_W'(LEN_POS);
    localparam logic [CNT_W-1:0] POS_LO = CNT_W'(LEN_POS + 1);

    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cur_idx;
    logic [DATA_W-1:0] len_hi_q;

    assign cur_idx   = in_sof ? '0 : idx_q;
    assign at_len_lo = in_valid && (cur_idx == POS_LO);
    assign len_val   = {len_hi_q, in_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            len_hi_q <= '0;
        end else if (in_valid) begin
            if (in_sof)
                idx_q <= CNT_W'(1);
            else if (idx_q <= POS_LO)
                idx_q <= idx_q + CNT_W'(1);
            if (cur_idx == POS_HI)
                len_hi_q <= in_data;
        end
    end
endmodule

// File: rtl/rxs_fsm.sv
// Frame state machine: decides keep/drop and end-marker placement.
module rxs_fsm
    import rxs_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int MIN_PAYLOAD = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_en,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             at_len_lo,
    input  logic [LEN_W-1:0] len_val,
    output logic             keep,
    output logic             mark_eof
);
    localparam int REM_W = $clog2(MIN_PAYLOAD + 1);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_PAYLOAD);

    rxs_state_e       state_q, state_d, cur;
    logic             en_q;
    logic [REM_W-1:0] rem_q, rem_d;
    logic             do_strip;

    assign do_strip = en_q && (len_val < MIN_LEN);
    assign cur      = in_sof ? S_HDR : state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            if (in_valid && in_sof)
                en_q <= strip_en;
        end
    end

    always_comb begin
        state_d  = state_q;
        rem_d    = rem_q;
        keep     = 1'b0;
        mark_eof = 1'b0;
        if (in_valid) begin
            unique case (cur)
                S_IDLE: state_d = S_IDLE;
                S_HDR: begin
                    keep    = 1'b1;
                    state_d = S_HDR;
                    if (at_len_lo) begin
                        if (!do_strip)
                            state_d = S_PASS;
                        else if (len_val == '0) begin
                            mark_eof = 1'b1;
                            state_d  = S_DROP;
                        end else begin
                            rem_d   = REM_W'(len_val);
                            state_d = S_KEEP;
                        end
                    end
                    if (in_eof)
                        state_d = S_IDLE;
                end
                S_PASS: begin
                    keep    = 1'b1;
                    state_d = in_eof ? S_IDLE : S_PASS;
                end
                S_KEEP: begin
                    keep = 1'b1;
                    if (rem_q == REM_W'(1)) begin
                        mark_eof = 1'b1;
                        state_d  = in_eof ? S_IDLE : S_DROP;
                    end else begin
                        rem_d   = rem_q - REM_W'(1);
                        state_d = in_eof ? S_IDLE : S_KEEP;
                    end
                end
                S_DROP: state_d = in_eof ? S_IDLE : S_DROP;
                default: state_d = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxs_out_stage.sv
// Output register: one cycle of latency, suppressed bytes leave valid low.
module rxs_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              keep,
    input  logic              mark_eof,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [DATA_W-1:0] out_data
);
    logic fwd;
    assign fwd = in_valid && keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fwd;
            out_sof   <= fwd && in_sof;
            out_eof   <= fwd && (in_eof || mark_eof);
            if (in_valid)
                out_data <= in_data;
        end
    end
endmodule

// File: rtl/rxs_pad_strip.sv
module rxs_pad_strip #(
    parameter int DATA_W      = 8,
    parameter int LEN_POS     = 12,
    parameter int MIN_PAYLOAD = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strip_en,
    input  logic              csum_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [DATA_W-1:0] out_data,
    output logic              cfg_err
);
    localparam int LEN_W = 2 * DATA_W;

    logic             at_len_lo;
    logic [LEN_W-1:0] len_val;
    logic             keep;
    logic             mark_eof;

    rxs_hdr_track #(.DATA_W(DATA_W), .LEN_POS(LEN_POS)) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .at_len_lo (at_len_lo),
        .len_val   (len_val)
    );

    rxs_fsm #(.LEN_W(LEN_W), .MIN_PAYLOAD(MIN_PAYLOAD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strip_en  (strip_en),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .at_len_lo (at_len_lo),
        .len_val   (len_val),
        .keep      (keep),
        .mark_eof  (mark_eof)
    );

    rxs_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .keep      (keep),
        .mark_eof  (mark_eof),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_data  (out_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else
            cfg_err <= strip_en && csum_en;
    end
endmodule

// File: rtl/rxs_pad_strip_chk.sv
module rxs_pad_strip_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strip_en,
    input logic              csum_en,
    input logic              in_valid,
    input logic              in_sof,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_sof,
    input logic              out_eof,
    input logic [DATA_W-1:0] out_data,
    input logic              cfg_err
);
    AST_CFG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_en && csum_en) |=> cfg_err); // R8
    AST_CFG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(strip_en && csum_en) |=> !cfg_err); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_DATA_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (out_data == $past(in_data))); // R7
    AST_SOF_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (out_valid && out_sof)); // R9
    AST_EOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid); // R4
endmodule

bind rxs_pad_strip rxs_pad_strip_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strip_en  (strip_en),
    .csum_en   (csum_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data),
    .cfg_err   (cfg_err)
);

// File: tb/tb_rxs_pad_strip.sv
module tb_rxs_pad_strip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strip_en = 1'b0;
    logic       csum_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid, out_sof, out_eof, cfg_err;
    logic [7:0] out_data;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    rxs_pad_strip dut (
        .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .csum_en(csum_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_data(out_data), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard as outputs appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL %s unexpected byte actual=%h expected=none", cur_req, out_data);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {6'b0, out_sof, out_eof, out_data}, {6'b0, e});
            end
        end
    end

    // driver: one frame; expected output computed from the requirements
    task automatic send_frame(input logic [15:0] len, input int n, input bit en,
                              input int gap, input bit no_eof, input bit flip,
                              input string req);
        bit strip;
        strip = en && (len < 16'd46);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            bit kept, last, e_exp;
            d = (i == 12) ? len[15:8] : (i == 13) ? len[7:0] : 8'(i * 7 + n);
            last = (i == n - 1) && !no_eof;
            kept = !strip || (i <= 13 + int'(len));
            e_exp = last || (strip && i == 13 + int'(len));
            if (i == 0) strip_en = en;
            if (flip && i == 1) strip_en = !en;
            in_valid = 1'b1; in_sof = (i == 0); in_eof = last; in_data = d;
            if (kept) begin
                exp_q.push_back({(i == 0), e_exp, d});
                tag_q.push_back(req);
            end
            @(negedge clk);
            if (gap != 0 && (i % gap) == gap - 1) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset out_valid", {15'b0, out_valid}, 16'd0);
        check("R8 reset cfg_err", {15'b0, cfg_err}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        send_frame(16'd10, 64, 1'b0, 0, 1'b0, 1'b0, "R1 disabled short");
        send_frame(16'd10, 64, 1'b1, 0, 1'b0, 1'b0, "R3 strip L=10");
        send_frame(16'd0, 60, 1'b1, 5, 1'b0, 1'b0, "R4 strip L=0");
        send_frame(16'd45, 64, 1'b1, 3, 1'b0, 1'b0, "R3 strip L=45");
        send_frame(16'd46, 64, 1'b1, 0, 1'b0, 1'b0, "R5 L=46");
        send_frame(16'h0800, 70, 1'b1, 4, 1'b0, 1'b0, "R5 ethertype");
        send_frame(16'd40, 30, 1'b1, 0, 1'b0, 1'b0, "R6 runt");
        send_frame(16'd5, 64, 1'b1, 2, 1'b0, 1'b1, "R2 enable sampled at sof");
        send_frame(16'd5, 64, 1'b0, 0, 1'b0, 1'b1, "R2 enable off at sof");
        send_frame(16'd20, 64, 1'b1, 7, 1'b0, 1'b0, "R7 idle gaps L=20");

        // R10: stray byte between frames must not appear
        cur_req = "R10 stray byte";
        in_valid = 1'b1; in_data = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 queue after stray", 16'(exp_q.size()), 16'd0);

        // R9: frame cut without end marker, next frame restarts counting
        send_frame(16'd3, 9, 1'b1, 0, 1'b1, 1'b0, "R9 cut frame");
        send_frame(16'd3, 40, 1'b1, 0, 1'b0, 1'b0, "R9 restarted frame");

        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", 16'(exp_q.size()), 16'd0);

        // R8 configuration conflict flag
        strip_en = 1'b1; csum_en = 1'b1;
        @(negedge clk);
        check("R8 both enables", {15'b0, cfg_err}, 16'd1);
        strip_en = 1'b0;
        @(negedge clk);
        check("R8 only csum", {15'b0, cfg_err}, 16'd0);
        strip_en = 1'b1; csum_en = 1'b0;
        @(negedge clk);
        check("R8 only strip", {15'b0, cfg_err}, 16'd0);

        finish_run();
    end
endmodule